// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a 256-location, 8-bit-wide non-volatile memory model behind a two-wire (I2C-style) slave port. Both bus lines are oversampled by the system clock and cleaned by a digital glitch filter. START and STOP are then recognised on the filtered lines, and the block walks a byte-oriented protocol: a select byte, an optional word address, then write data or read data. SDA is never driven high. The block only pulls it low through an output-enable, and the line is expected to be wired-AND with a pull-up outside the block.

Writes are held in a one-byte buffer. They reach the array only after a STOP, and then only after an internal write cycle of a parameterised number of system clocks. A write-protect input refuses writes outright. It also cancels a pending write when it is seen high at any point from the capture of the data byte's last bit to the end of that write cycle. While the write cycle runs, the block ignores its own select byte. Reads may be random (set the address with a write-direction select, then a repeated START and a read select) or may continue from the internal address pointer.

Top module: `tw_eeprom`

## Requirements
- R1: After reset every location reads FFh, SDA is released (`sda_oe` low) and the address pointer is 00h.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before the first START the block never drives SDA, even when a matching select byte is clocked in.
- R3: The select byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `dev_pins[2:0]`. On any mismatch the block leaves the acknowledge slot high and stays silent until the next START.
- R4: The block acknowledges by pulling SDA low in the ninth clock for a matching select byte, the word address and the first write data byte. Input bits are taken on SCL rising, and driven SDA changes only after SCL falling.
- R5: A write is committed only when the transaction ends with a STOP. A repeated START or a new START after the data byte discards it.
- R6: Bit 0 of the select byte is 1 for read and 0 for write. A write select plus a word address, followed by a repeated START and a read select, returns the byte at that address.
- R7: The pointer advances after every byte sent and wraps from FFh to 00h. A read continues while the master acknowledges. After a master no-acknowledge the block releases SDA and sends nothing more.
- R8: For WR_CYC system clocks after the committing STOP, select bytes are not acknowledged. After that they are acknowledged again.
- R9: If WP is high at any time from the SCL rise capturing bit 0 of the data byte until the end of the write cycle, the array is left unchanged. With WP low throughout, the write succeeds.
- R10: Pulses on SCL or SDA that last fewer than FILT_CYC system clocks have no effect on the protocol.
- R11: Only one data byte is buffered per write. Further data bytes are not acknowledged and are discarded, and the first byte is still committed at STOP.
- R12: A write leaves the pointer at the word address that was sent, so a following current-address read returns the byte just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND result) |
| sda_oe | output | 1 | When high, the data line is pulled low |
| dev_pins | input | 3 | Strap levels compared with select bits 3..1 |
| wp_i | input | 1 | Write protect, active high |

## Verification
On every cycle the assertions check the following. SDA is released in the idle and skip states and after a STOP. A START always rearms reception at bit zero. A select byte is never acknowledged while a write cycle runs. Protect rising during a write cycle aborts that cycle. The glitch filter only ever takes a value its synchroniser has held. Everything that depends on array contents needs the bench's bus scenarios to show it: commit only on STOP, discard of an unterminated or protected write, buffering of only one byte, pointer wrap across FFh and the read-back of random writes.

// File: rtl/eeprom_pkg.sv
// Shared types for the two-wire serial byte memory.
// Assumes: bytes are 8 bits and travel MSB first.
package eeprom_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte
        ST_ACKW,   // byte done, waiting for SCL fall to open ack slot
        ST_ACKH,   // holding ack low, waiting for SCL fall to close it
        ST_TX,     // shifting out a read byte
        ST_MACK,   // master acknowledge slot after a read byte
        ST_SKIP    // not addressed: silent until START/STOP
    } bus_state_t;

    // What the byte being received means
    typedef enum logic [1:0] {
        RX_SEL,    // select byte
        RX_WORD,   // word address
        RX_DATA,   // first write data byte
        RX_EXTRA   // any further write byte (refused)
    } rx_kind_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/line_filter.sv
// Glitch filter for one bus line.
// Does: synchronises the line with two flops, then accepts a new level only
// after it has held for STABLE_CYC consecutive clocks.
// Assumes: STABLE_CYC >= 2; idle level of the line is high.
module line_filter #(
    parameter int STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic       meta_q, sync_q;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Stability counter: adopt the new level after STABLE_CYC disagreeing clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= 1'b1;
            run_q   <= '0;
        end else if (sync_q == clean_o) begin
            run_q   <= '0;
        end else if (run_q == CW'(STABLE_CYC - 1)) begin
            clean_o <= sync_q;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    // R10
    filt_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(sync_q) == clean_o));

endmodule

// File: rtl/ee_byte_array.sv
// Byte storage array.
// Does: one synchronous write port, one combinational read port; every
// location returns to all ones on reset (erased state).
// Assumes: write address and data are stable in the cycle we is high.
module ee_byte_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Erase on reset, single-location write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/tw_eeprom.sv
// Two-wire serial byte memory slave (top).
// Does: filters SCL/SDA, detects START/STOP, decodes select byte, word
// address and one write byte, serves reads from an auto-incrementing
// pointer, commits writes after STOP plus a WR_CYC-clock write cycle, and
// honours a write-protect input that blocks or cancels writes.
// Assumes: ADDR_W = 8 (one word-address byte); SDA is open drain outside,
// sda_i is the resolved wire; the master changes SDA only while SCL is low
// except for START/STOP.
module tw_eeprom
    import eeprom_pkg::*;
#(
    parameter int FILT_CYC = 4,
    parameter int WR_CYC   = 250000,
    parameter int ADDR_W   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_pins,
    input  logic       wp_i
);
    localparam int DW  = 8;
    localparam int WCW = $clog2(WR_CYC + 1);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        line_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    logic wp_m, wp_s;
    assign scl_f = clean_lines[0];
    assign sda_f = clean_lines[1];

    // Previous filtered levels for edge detection, and WP synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            wp_m  <= 1'b0;
            wp_s  <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wp_m  <= wp_i;
            wp_s  <= wp_m;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

    // ---------------- storage ----------------
    logic [ADDR_W-1:0] ptr, wr_addr;
    logic [DW-1:0]     wr_data, mem_rd;
    logic              mem_we, busy;
    logic [WCW-1:0]    wcnt;

    assign mem_we = busy && (wcnt == '0) && !wp_s;

    ee_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(ptr),
        .rd_data(mem_rd)
    );

    // ---------------- protocol engine ----------------
    bus_state_t state;
    rx_kind_t   kind;
    logic [2:0] bitcnt;
    logic [7:0] shreg, rx_byte;
    logic       ack_ok, go_read, m_ack, pend, cancel, dev_match;

    assign rx_byte   = {shreg[6:0], sda_f};
    assign dev_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_pins);

    // Bus protocol, write buffer, write-cycle timer and protect handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= RX_SEL;
            bitcnt  <= '0;
            shreg   <= '0;
            ack_ok  <= 1'b0;
            go_read <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            pend    <= 1'b0;
            cancel  <= 1'b0;
            busy    <= 1'b0;
            wcnt    <= '0;
        end else begin
            // internal write cycle: protect aborts it, expiry ends it
            if (busy) begin
                if (wp_s || wcnt == '0) busy <= 1'b0;
                else                    wcnt <= wcnt - 1'b1;
            end
            if (pend && wp_s) cancel <= 1'b1;

            if (start_det) begin
                state  <= ST_RX;
                kind   <= RX_SEL;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
                cancel <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (pend && !cancel && !wp_s) begin
                    busy <= 1'b1;
                    wcnt <= WCW'(WR_CYC - 1);
                end
                pend   <= 1'b0;
                cancel <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) begin
                            state <= ST_ACKW;
                            unique case (kind)
                                RX_SEL: begin
                                    ack_ok  <= dev_match && !busy;
                                    go_read <= rx_byte[0];
                                end
                                RX_WORD: begin
                                    ack_ok <= 1'b1;
                                    ptr    <= rx_byte[ADDR_W-1:0];
                                end
                                RX_DATA: begin
                                    ack_ok  <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_byte;
                                    pend    <= 1'b1;
                                    cancel  <= wp_s;
                                end
                                default: ack_ok <= 1'b0;
                            endcase
                        end
                    end
                    ST_ACKW: if (scl_fall) begin
                        sda_oe <= ack_ok;
                        state  <= ack_ok ? ST_ACKH : ST_SKIP;
                    end
                    ST_ACKH: if (scl_fall) begin
                        bitcnt <= '0;
                        if (kind == RX_SEL && go_read) begin
                            state  <= ST_TX;
                            sda_oe <= ~mem_rd[7];
                            shreg  <= {mem_rd[6:0], 1'b0};
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            unique case (kind)
                                RX_SEL:  kind <= RX_WORD;
                                RX_WORD: kind <= RX_DATA;
                                default: kind <= RX_EXTRA;
                            endcase
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe <= ~shreg[7];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) m_ack <= ~sda_f;
                        if (scl_fall) begin
                            if (m_ack) begin
                                state  <= ST_TX;
                                sda_oe <= ~mem_rd[7];
                                shreg  <= {mem_rd[6:0], 1'b0};
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R2
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && bitcnt == 3'd0));

    // R3
    quiet_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACKW && kind == RX_SEL && busy) |-> !ack_ok);

    // R9
    wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wp_s) |=> !busy);

endmodule

// File: tb/sim_tw_eeprom.sv
// Bench for tw_eeprom: directed corner cases plus seeded random byte traffic,
// compared against a reference array and pointer kept in the bench.
module sim_tw_eeprom;
    localparam int FILT = 3;
    localparam int WRC  = 600;
    localparam int Q    = 8;    // quarter bit period in system clocks

    logic clk = 1'b0;
    always #10 clk = ~clk;      // 50 MHz

    logic       rst_n, scl_m, sda_m, wp, sda_oe, sda_bus;
    logic [2:0] pins;
    assign sda_bus = sda_m & ~sda_oe;

    tw_eeprom #(.FILT_CYC(FILT), .WR_CYC(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .dev_pins(pins), .wp_i(wp)
    );

    int         n_cmp = 0, n_bad = 0;
    bit         glitch = 1'b0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(bit rd);
        return {4'b1010, pins, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q-4);
            end else tick(Q);
            scl_m = 1'b1;
            if (glitch && b[i]) begin
                tick(Q-1); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q-1);
            end else tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q); scl_m = 1'b0;
        end
        sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q); sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        bus_start(); put_byte(sel(0), k1); put_byte(a, k2); put_byte(d, k3); bus_stop();
        ok = k1 & k2 & k3;
        ref_ptr = a;
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        bus_start(); put_byte(sel(0), k1); put_byte(a, k2);
        bus_start(); put_byte(sel(1), k3); get_byte(1'b0, d); bus_stop();
        ok = k1 & k2 & k3;
        ref_ptr = a + 8'd1;
    endtask

    task automatic cur_read(output logic [7:0] d, output bit ok);
        bus_start(); put_byte(sel(1), ok); get_byte(1'b0, d); bus_stop();
        ref_ptr = ref_ptr + 8'd1;
    endtask

    task automatic wait_wr();
        tick(WRC + 40);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        tick(180000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d, e;
        bit ok, k;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        ref_ptr = 8'h00;
        scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; pins = 3'b101; rst_n = 1'b0;
        tick(5);
        check("R1 sda released in reset", sda_oe, 1'b0);
        rst_n = 1'b1; tick(5);

        // R1: erased contents
        cur_read(d, ok); check("R1 pointer starts at 00 / read FF", d, 8'hFF);
        rand_read(8'h7F, d, ok); check("R1 location 7F erased", d, 8'hFF);
        rand_read(8'hFF, d, ok); check("R1 location FF erased", d, 8'hFF);

        // R2: matching select clocked without START is ignored
        put_byte(sel(0), k); check("R2 no ack before START", k, 1'b0);
        bus_stop();

        // R3: select mismatches
        bus_start(); put_byte({4'b1010, 3'b100, 1'b0}, k);
        check("R3 pin mismatch nack", k, 1'b0); bus_stop();
        bus_start(); put_byte({4'b1011, pins, 1'b0}, k);
        check("R3 type mismatch nack", k, 1'b0); bus_stop();

        // R4/R5/R6: basic write and random read
        do_write(8'h10, 8'h3C, ok); check("R4 write acks", ok, 1'b1);
        ref_mem[8'h10] = 8'h3C; wait_wr();
        rand_read(8'h10, d, ok); check("R6 random read", d, 8'h3C);
        check("R4 read select acked", ok, 1'b1);

        // R8: select refused during write cycle, accepted after
        do_write(8'h20, 8'hA5, ok); ref_mem[8'h20] = 8'hA5;
        bus_start(); put_byte(sel(0), k); check("R8 nack while writing", k, 1'b0);
        bus_stop(); wait_wr();
        bus_start(); put_byte(sel(0), k); check("R8 ack after write cycle", k, 1'b1);
        bus_stop();
        rand_read(8'h20, d, ok); check("R8 written value", d, 8'hA5);

        // R12: pointer stays at written address
        do_write(8'h30, 8'h5A, ok); ref_mem[8'h30] = 8'h5A; wait_wr();
        cur_read(d, ok); check("R12 current read after write", d, 8'h5A);

        // R7: wrap and sequential read, release after master nack
        do_write(8'hFF, 8'h77, ok); ref_mem[8'hFF] = 8'h77; wait_wr();
        rand_read(8'hFF, d, ok); check("R7 read at FF", d, 8'h77);
        cur_read(d, ok); check("R7 wrap to 00", d, ref_mem[8'h00]);
        rand_read(8'hFD, d, ok);
        bus_start(); put_byte(sel(1), k);
        for (int j = 0; j < 3; j++) begin
            get_byte(j != 2, d);
            check("R7 sequential read", d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 8'd1;
        end
        tick(Q); check("R7 released after nack", sda_oe, 1'b0);
        bus_stop();

        // R5: no STOP, repeated START discards the write
        bus_start(); put_byte(sel(0), k); put_byte(8'h40, k); put_byte(8'h11, k);
        rand_read(8'h40, d, ok); check("R5 unterminated write discarded", d, 8'hFF);

        // R9: protect cases
        wp = 1'b1; do_write(8'h50, 8'h22, ok); wp = 1'b0; wait_wr();
        rand_read(8'h50, d, ok); check("R9 protected throughout", d, 8'hFF);
        bus_start(); put_byte(sel(0), k); put_byte(8'h50, k);
        wp = 1'b1; put_byte(8'h22, k); wp = 1'b0; tick(Q); bus_stop(); wait_wr();
        rand_read(8'h50, d, ok); check("R9 protect at data byte", d, 8'hFF);
        do_write(8'h50, 8'h22, ok); tick(100); wp = 1'b1; tick(8); wp = 1'b0; wait_wr();
        rand_read(8'h50, d, ok); check("R9 protect during write cycle", d, 8'hFF);
        do_write(8'h50, 8'h22, ok); ref_mem[8'h50] = 8'h22; wait_wr();
        rand_read(8'h50, d, ok); check("R9 unprotected write", d, 8'h22);

        // R11: second data byte refused
        bus_start(); put_byte(sel(0), k); put_byte(8'h60, k); put_byte(8'h9E, k);
        put_byte(8'h44, k); check("R11 extra byte nack", k, 1'b0);
        bus_stop(); ref_mem[8'h60] = 8'h9E; wait_wr();
        rand_read(8'h60, d, ok); check("R11 first byte kept", d, 8'h9E);
        rand_read(8'h61, d, ok); check("R11 extra byte discarded", d, 8'hFF);

        // R10: glitches on both lines
        glitch = 1'b1; do_write(8'h70, 8'hB5, ok); glitch = 1'b0;
        check("R10 acks with glitches", ok, 1'b1);
        ref_mem[8'h70] = 8'hB5; wait_wr();
        rand_read(8'h70, d, ok); check("R10 data through glitches", d, 8'hB5);

        // Random traffic
        for (int it = 0; it < 24; it++) begin
            logic [7:0] a, v;
            int op;
            op = $urandom_range(0, 2);
            a  = 8'($urandom_range(0, 255));
            v  = 8'($urandom_range(0, 255));
            if (op == 0) begin
                do_write(a, v, ok); ref_mem[a] = v; wait_wr();
                check("R4 random write acks", ok, 1'b1);
            end else if (op == 1) begin
                rand_read(a, d, ok); check("R6 random read", d, ref_mem[a]);
            end else begin
                e = ref_mem[ref_ptr];
                cur_read(d, ok); check("R7 random current read", d, e);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule